// File: doc/BRIEF.md
# Multiplexed Bus Cycle Sequencer

This block sequences the control strobes of a 16-bit processor bus whose address and data share the same wires. A requester presents an address, a read or write flag, a word or byte size and a refresh flag. Once the block accepts the request, it walks the bus through the states T1, T2, T3, optional waits (TW) and T4. Along the way it drives an address-latch pulse, active-low read and write strobes, an active-low upper-byte enable and address bit 0. Each strobe that can float has an output-enable, which stands in for the tristate pin.

A hold request lets another master take the bus, but only at a cycle boundary. While hold is granted, the read strobe, the write strobe and the upper-byte enable are released. A strap input is sampled while reset is active. If the strap is low, the latch-enable pin and the write pin carry a two-bit instruction-queue status instead of their normal strobes. The data path and the queue itself are outside this block.

Top module: `mux_bus_seq`

## Requirements
- R1: In the first clock of reset, rd_n and wr_n_qs1 are 1 and rd_oe, wr_oe and bhe_oe are 1. In later reset clocks those enables are 0. After reset the bus is idle: ale_qs0=0, rd_n=1, wr_n_qs1=1, bhe_n=1, a0=0, addr_oe=0, hold_ack=0, and all enables are 1.
- R2: The value of rd_strap in the last reset clock picks the mode. A value of 1 selects normal strobes. A value of 0 selects queue-status mode.
- R3: req_accept is 1 in a cycle when the bus is idle or in T4, hold_req is 0 and req_valid is 1. The cycle after acceptance is T1. It is followed by T2 and T3, then T4 once ready was 1 at the end of T3 or TW, and then idle.
- R4: In normal mode, ale_qs0 is 1 exactly during T1. During that time addr_oe is 1 and bus_addr holds the accepted address. addr_oe is 0 in every other state.
- R5: rd_n is 0 exactly in T2, T3 and TW of a read or refresh cycle, and addr_oe is 0 whenever rd_n is 0.
- R6: In normal mode, wr_n_qs1 is 0 exactly in T2, T3 and TW of a write cycle that is not a refresh. A refresh is always run as a read.
- R7: From T1 through TW the pair {bhe_n,a0} is {0,0} for a word, {0,1} for an upper byte (byte with address bit 0 = 1), {1,0} for a lower byte (byte with address bit 0 = 0) and {1,1} for a refresh. Outside a cycle the pair is {1,0}.
- R8: When ready is 0 at the end of T3 or TW, another TW follows. In that TW every strobe keeps the value it had.
- R9: hold_ack rises only after idle or T4, never in the middle of a cycle. While hold_ack is 1, rd_oe and bhe_oe are 0, wr_oe is 0 in normal mode, ale_qs0 is 0 in normal mode, and req_accept is 0.
- R10: In queue-status mode, {wr_n_qs1,ale_qs0} equals qs_in delayed by one clock (00 none, 01 first opcode byte, 10 queue emptied, 11 subsequent byte). wr_oe stays 1, including during hold. rd_n, bhe_n and a0 behave as in normal mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rd_strap | input | 1 | Mode strap sampled during reset, 0 selects queue-status mode |
| req_valid | input | 1 | Bus cycle request pending |
| req_addr | input | AW | Request address |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_word | input | 1 | 1 for a word transfer, 0 for a byte |
| req_refresh | input | 1 | 1 for a refresh cycle |
| req_accept | output | 1 | The request is taken at this clock edge |
| ready | input | 1 | 0 at the end of T3 or TW inserts a wait |
| hold_req | input | 1 | Another master requests the bus |
| qs_in | input | 2 | Queue status to show in queue-status mode |
| hold_ack | output | 1 | Bus released to the other master |
| bus_addr | output | AW | Address on the multiplexed bus |
| addr_oe | output | 1 | Address drive enable (T1 only) |
| ale_qs0 | output | 1 | Address latch enable, or queue status bit 0 |
| wr_n_qs1 | output | 1 | Write strobe (active low), or queue status bit 1 |
| wr_oe | output | 1 | Enable for wr_n_qs1 |
| rd_n | output | 1 | Read strobe, active low |
| rd_oe | output | 1 | Enable for rd_n |
| bhe_n | output | 1 | Upper-byte enable, active low |
| bhe_oe | output | 1 | Enable for bhe_n |
| a0 | output | 1 | Address bit 0 / lower lane select |

## Verification
The assertions assume a few things about the inputs. ready is meaningful only at the end of T3 and TW. A request stays valid until req_accept. rd_strap is stable over the last reset clock. The bench drives every input on the falling edge and holds req_valid until acceptance. It drives ready low for a chosen number of wait states, starting in T3. It raises hold_req in the middle of a cycle and while idle, so a hold request arrives at both kinds of point. Random requests draw the size, the direction, the refresh flag, the address parity and a wait count of zero to three.

// File: rtl/mux_bus_seq.sv
module mux_bus_seq #(
  parameter int AW = 20
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_strap,
  input  logic          req_valid,
  input  logic [AW-1:0] req_addr,
  input  logic          req_write,
  input  logic          req_word,
  input  logic          req_refresh,
  output logic          req_accept,
  input  logic          ready,
  input  logic          hold_req,
  input  logic [1:0]    qs_in,
  output logic          hold_ack,
  output logic [AW-1:0] bus_addr,
  output logic          addr_oe,
  output logic          ale_qs0,
  output logic          wr_n_qs1,
  output logic          wr_oe,
  output logic          rd_n,
  output logic          rd_oe,
  output logic          bhe_n,
  output logic          bhe_oe,
  output logic          a0
);

  typedef enum logic [2:0] {S_IDLE, S_T1, S_T2, S_T3, S_TW, S_T4, S_HOLD} st_t;

  st_t           st, st_nx;
  logic          qmode, rst_q;
  logic [1:0]    qs_q;
  logic [AW-1:0] addr_r;
  logic          wr_r, word_r, ref_r;
  logic          boundary, in_cyc, strobe, drv;
  logic          bhe_v, a0_v;

  assign boundary   = (st == S_IDLE) || (st == S_T4);
  assign req_accept = boundary && !hold_req && req_valid && !rst;

  always_comb begin
    st_nx = st;
    case (st)
      S_IDLE, S_T4: begin
        if (hold_req)       st_nx = S_HOLD;
        else if (req_valid) st_nx = S_T1;
        else                st_nx = S_IDLE;
      end
      S_T1:   st_nx = S_T2;
      S_T2:   st_nx = S_T3;
      S_T3,
      S_TW:   st_nx = ready ? S_T4 : S_TW;
      S_HOLD: st_nx = hold_req ? S_HOLD : S_IDLE;
      default: st_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    rst_q <= rst;
    qs_q  <= qs_in;
    if (rst) begin
      st    <= S_IDLE;
      qmode <= !rd_strap;
    end else begin
      st <= st_nx;
    end
    if (req_accept) begin
      addr_r <= req_addr;
      wr_r   <= req_write && !req_refresh;
      word_r <= req_word;
      ref_r  <= req_refresh;
    end
  end

  assign in_cyc = !rst && (st inside {S_T1, S_T2, S_T3, S_TW});
  assign strobe = !rst && (st inside {S_T2, S_T3, S_TW});
  assign drv    = rst ? !rst_q : (st != S_HOLD);

  assign bhe_v = ref_r ? 1'b1 : (word_r ? 1'b0 : !addr_r[0]);
  assign a0_v  = ref_r ? 1'b1 : (word_r ? 1'b0 : addr_r[0]);

  assign hold_ack = !rst && (st == S_HOLD);
  assign bus_addr = addr_r;
  assign addr_oe  = !rst && (st == S_T1);

  assign ale_qs0  = qmode ? qs_q[0] : addr_oe;
  assign wr_n_qs1 = qmode ? qs_q[1] : !(strobe && wr_r);
  assign rd_n     = !(strobe && !wr_r);
  assign bhe_n    = in_cyc ? bhe_v : 1'b1;
  assign a0       = in_cyc && a0_v;

  assign rd_oe  = drv;
  assign bhe_oe = drv;
  assign wr_oe  = qmode ? 1'b1 : drv;

endmodule

module mux_bus_seq_chk (
  input logic clk,
  input logic rst,
  input logic qmode,
  input logic ready,
  input logic hold_ack,
  input logic req_accept,
  input logic addr_oe,
  input logic ale_qs0,
  input logic wr_n_qs1,
  input logic wr_oe,
  input logic rd_n,
  input logic rd_oe,
  input logic bhe_n,
  input logic bhe_oe
);

  // R4
  ale_addr_chk: assert property (@(posedge clk) disable iff (rst)
    (!qmode && ale_qs0) |-> addr_oe);

  // R4
  ale_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (!qmode && ale_qs0) |=> !ale_qs0);

  // R5
  rd_released_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_n |-> !addr_oe);

  // R6
  rd_wr_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !qmode |-> (rd_n || wr_n_qs1));

  // R8
  rd_wait_chk: assert property (@(posedge clk) disable iff (rst)
    (!rd_n && !ready) |=> !rd_n);

  // R8
  bhe_wait_chk: assert property (@(posedge clk) disable iff (rst)
    (!bhe_n && !addr_oe && !ready) |=> (!bhe_n && $stable(rd_n)));

  // R9
  hold_float_chk: assert property (@(posedge clk) disable iff (rst)
    hold_ack |-> (!rd_oe && !bhe_oe && !req_accept && (qmode || !wr_oe)));

  // R9
  hold_boundary_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(hold_ack) |-> $past(rd_n && bhe_n && !addr_oe));

  // R10
  qs_drive_chk: assert property (@(posedge clk) disable iff (rst)
    qmode |-> wr_oe);

endmodule

bind mux_bus_seq mux_bus_seq_chk u_chk (.*);

// File: tb/mux_bus_seq_tb.sv
module mux_bus_seq_tb;
  localparam int AW = 20;
  localparam int PH_T1 = 1, PH_T2 = 2, PH_T3 = 3, PH_TW = 4, PH_T4 = 5;

  logic clk = 0, rst = 1, rd_strap = 1;
  logic req_valid = 0, req_write = 0, req_word = 0, req_refresh = 0;
  logic [AW-1:0] req_addr = '0;
  logic ready = 1, hold_req = 0;
  logic [1:0] qs_in = 2'b00;
  logic req_accept, hold_ack, addr_oe, ale_qs0, wr_n_qs1, wr_oe;
  logic rd_n, rd_oe, bhe_n, bhe_oe, a0;
  logic [AW-1:0] bus_addr;

  int n_chk = 0, n_bad = 0;
  logic qm_b = 0;
  logic [1:0] qs_b = 2'b00;

  always #2 clk = ~clk;

  mux_bus_seq #(.AW(AW)) u_dut (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [5:0] exp_pins(int ph, logic [AW-1:0] ad, logic w, logic wd, logic rf);
    logic cyc, st, ale, rdn, wrn, bhen, a0e, w_eff;
    cyc = (ph >= PH_T1) && (ph <= PH_TW);
    st  = (ph >= PH_T2) && (ph <= PH_TW);
    w_eff = w && !rf;
    ale = (ph == PH_T1);
    rdn = !(st && !w_eff);
    wrn = !(st && w_eff);
    bhen = cyc ? (rf ? 1'b1 : (wd ? 1'b0 : !ad[0])) : 1'b1;
    a0e  = cyc ? (rf ? 1'b1 : (wd ? 1'b0 : ad[0])) : 1'b0;
    if (qm_b) begin
      ale = qs_b[0];
      wrn = qs_b[1];
    end
    return {ale, rdn, wrn, bhen, a0e, (ph == PH_T1)};
  endfunction

  task automatic chk_ph(int ph, logic [AW-1:0] ad, logic w, logic wd, logic rf);
    chk($sformatf("R3 R4 R5 R6 R7 R8 R10 phase%0d {ale,rd,wr,bhe,a0,aoe}", ph),
        {ale_qs0, rd_n, wr_n_qs1, bhe_n, a0, addr_oe}, exp_pins(ph, ad, w, wd, rf));
  endtask

  task automatic do_cycle(logic [AW-1:0] ad, logic w, logic wd, logic rf, int nw);
    @(negedge clk);
    req_valid = 1; req_addr = ad; req_write = w; req_word = wd; req_refresh = rf; ready = 1;
    #1 chk("R3 accept", req_accept, 1);
    @(negedge clk);
    req_valid = 0;
    chk_ph(PH_T1, ad, w, wd, rf);
    chk("R4 bus_addr", bus_addr, ad);
    @(negedge clk); chk_ph(PH_T2, ad, w, wd, rf);
    chk("R3 accept low mid-cycle", req_accept, 0);
    @(negedge clk); chk_ph(PH_T3, ad, w, wd, rf);
    ready = (nw == 0);
    for (int i = 0; i < nw; i++) begin
      @(negedge clk); chk_ph(PH_TW, ad, w, wd, rf);
      ready = (i == nw - 1);
    end
    @(negedge clk); chk_ph(PH_T4, ad, w, wd, rf);
    ready = 1;
  endtask

  task automatic chk_idle(string tag);
    chk(tag, {ale_qs0, rd_n, wr_n_qs1, bhe_n, a0, addr_oe, hold_ack, rd_oe, wr_oe, bhe_oe},
        10'b0_1_1_1_0_0_0_1_1_1);
  endtask

  initial begin
    void'($urandom(32'h1d2c3b4a));
    repeat (3) @(negedge clk);
    rst = 0;
    #1 chk_idle("R1 idle after reset");
    chk("R2 normal mode strap high wr_oe", wr_oe, 1);

    do_cycle(20'h12340, 0, 1, 0, 0);
    do_cycle(20'h0A0B1, 1, 0, 0, 0);
    do_cycle(20'h0A0B2, 1, 0, 0, 1);
    do_cycle(20'h00003, 0, 0, 0, 2);
    do_cycle(20'hFFFFE, 1, 1, 1, 0);
    do_cycle(20'h55555, 0, 1, 0, 3);
    for (int k = 0; k < 40; k++)
      do_cycle($urandom, $urandom % 2, $urandom % 2, ($urandom % 8) == 0, $urandom % 4);

    // R9 hold raised mid-cycle
    @(negedge clk);
    req_valid = 1; req_addr = 20'h00101; req_write = 0; req_word = 0; req_refresh = 0;
    @(negedge clk); req_valid = 0;
    @(negedge clk); hold_req = 1;
    chk("R9 no hold in T2", hold_ack, 0);
    @(negedge clk); chk("R9 no hold in T3", hold_ack, 0);
    chk("R5 read continues under hold request", rd_n, 0);
    @(negedge clk); chk("R9 no hold in T4", hold_ack, 0);
    @(negedge clk);
    chk("R9 hold granted after T4", hold_ack, 1);
    chk("R9 floated enables", {rd_oe, wr_oe, bhe_oe, ale_qs0}, 4'b0000);
    req_valid = 1;
    #1 chk("R9 request held off", req_accept, 0);
    @(negedge clk); req_valid = 0; hold_req = 0;
    @(negedge clk); chk_idle("R9 released to idle");

    // R9 hold from idle
    hold_req = 1;
    @(negedge clk); chk("R9 hold from idle", hold_ack, 1);
    hold_req = 0;
    @(negedge clk); chk_idle("R9 idle again");

    // R1 reset drives high one clock, then floats
    rst = 1;
    #1 chk("R1 first reset clock driven high", {rd_n, wr_n_qs1, rd_oe, wr_oe, bhe_oe}, 5'b11111);
    @(negedge clk);
    chk("R1 later reset clock floated", {rd_oe, wr_oe, bhe_oe}, 3'b000);
    rd_strap = 0;
    @(negedge clk);
    rst = 0; rd_strap = 1;
    qm_b = 1;

    // R10 queue-status mode
    #1 chk("R2 strap low enables queue mode wr_oe", wr_oe, 1);
    for (int v = 0; v < 4; v++) begin
      qs_in = v[1:0];
      @(negedge clk);
      chk("R10 queue status on pins", {wr_n_qs1, ale_qs0}, v[1:0]);
    end
    qs_in = 2'b10; qs_b = 2'b10;
    @(negedge clk);
    do_cycle(20'h00201, 0, 0, 0, 1);
    do_cycle(20'h00300, 1, 1, 0, 0);
    hold_req = 1;
    @(negedge clk); @(negedge clk);
    chk("R10 hold in queue mode", {hold_ack, wr_oe, rd_oe, bhe_oe}, 4'b1100);
    hold_req = 0;
    @(negedge clk); @(negedge clk);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(4 * 150000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule